// File: doc/BRIEF.md
# Double-Buffered Serial Receive Port

This block receives a synchronous serial stream and presents it to a host one word at a time. A bit clock, an active-high frame sync and a data line come in from the serial side. They are sampled by the system clock. A falling edge of the bit clock moves one bit, most significant first, into a shift register. When a word is complete, it is copied into a holding register that the host reads. The copy happens only if the host has already consumed the previous word. The word length is a full 16-bit word or an 8-bit byte. Framing is either burst, with one sync pulse per word, or continuous, where the first sync starts a stream of words that follow back to back.

When a word completes and the holding register is still unread, the block does not overwrite the holding register. The new word stays in the shift register and an overrun flag is raised. Further bits and further sync pulses are ignored while this lasts. When the host next reads, the waiting word moves into the holding register on that clock edge. The interrupt pulses and the flag clears. The receive interrupt is a one-cycle pulse that marks each successful transfer and nothing else.

Top module: `serial_rx_dbuf`

## Requirements
- R1: Reset sets the following to zero: the holding register output, the unread flag, the overrun flag, the interrupt and the shift register state.
- R2: In burst framing, a word starts on a bit-clock falling edge that sees frame sync high. The first bit is taken on that edge. Each later falling edge shifts in one more bit, most significant bit first.
- R3: When byte_mode is 1, a word is 8 bits long and appears on rd_data[7:0] with rd_data[15:8] zero. When byte_mode is 0, a word is 16 bits long.
- R4: A completed word is copied to rd_data when the holding register has been read. The copy sets rx_unread to 1 and raises rx_irq for exactly one clock cycle.
- R5: A word that completes while rx_unread is 1 sets rx_ovr to 1 and leaves rd_data unchanged. Later bits and sync pulses are ignored until a host read, and rd_data stays unchanged.
- R6: rx_irq is raised only for a transfer into the holding register. An overrun raises no interrupt.
- R7: A one-cycle pulse on rd_strobe while rx_ovr is 1 does three things on the next clock edge: it moves the waiting word to rd_data, it clears rx_ovr and it pulses rx_irq. rx_unread stays 1.
- R8: A one-cycle pulse on rd_strobe with no word waiting clears rx_unread and leaves rd_data unchanged.
- R9: When cont_mode is 1, one sync pulse starts the stream. Each following group of word-length bits forms the next word with no sync pulse.
- R10: Overrun in continuous framing follows R5 and R7. After the waiting word is transferred, the next falling edge starts a new word.
- R11: In burst framing, once a word is complete the port waits for a new sync. Bits clocked in without sync are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects 8-bit words, 0 selects 16-bit words |
| cont_mode | input | 1 | 1 selects continuous framing, 0 selects burst framing |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| fsync | input | 1 | Active-high frame sync |
| sdata | input | 1 | Serial data, most significant bit first |
| rd_strobe | input | 1 | Host read pulse for the holding register |
| rd_data | output | 16 | Holding register contents |
| rx_irq | output | 1 | One-cycle receive interrupt on each transfer |
| rx_unread | output | 1 | Holding register holds a word not yet read |
| rx_ovr | output | 1 | Shift register full while the holding register is unread |

## Verification
The bench sends a second word and then a third sync-framed word while the first word is still unread. A design that lets the sync pulse force the copy would change rd_data and raise an extra interrupt. A design that lost the waiting word would later deliver the wrong value after the read. The bench also clocks bits without sync in burst mode, which a design that treats them as a frame would turn into a spurious word. It runs continuous streams with and without a host keeping up, which catches a design that loses bit alignment after an overrun is released. Byte mode is checked for correct length and zero upper bits.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_RUN,
        SH_FULL
    } sh_state_e;

    // one system-clock view of the serial side
    typedef struct packed {
        logic fall;
        logic fs;
        logic dat;
    } ser_evt_t;

    function automatic logic [CNT_W-1:0] frame_len(input logic byte_sel);
        return byte_sel ? CNT_W'(BYTE_W) : CNT_W'(WORD_W);
    endfunction

    function automatic logic [WORD_W-1:0] fit_word(input logic byte_sel,
                                                   input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] m;
        m = byte_sel ? {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {WORD_W{1'b1}};
        return w & m;
    endfunction

endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync
    import srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     fsync,
    input  logic     sdata,
    output ser_evt_t evt
);
    logic [1:0] clk_pipe;
    logic       fs_q;
    logic       dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_pipe <= '0;
            fs_q     <= 1'b0;
            dat_q    <= 1'b0;
        end else begin
            clk_pipe <= {clk_pipe[0], sclk};
            fs_q     <= fsync;
            dat_q    <= sdata;
        end
    end

    always_comb begin
        evt.fall = clk_pipe[1] & ~clk_pipe[0];
        evt.fs   = fs_q;
        evt.dat  = dat_q;
    end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         byte_mode,
    input  logic         cont_mode,
    input  ser_evt_t     evt,
    input  logic         hold_free,
    output logic         xfer,
    output logic [W-1:0] xfer_word,
    output logic         sh_full
);
    sh_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [W-1:0]     sh_q, sh_n;
    logic [CNT_W-1:0] len;
    logic             take;
    logic             last;
    logic [W-1:0]     shifted;
    sh_state_e        resume;

    always_comb begin
        len     = frame_len(byte_mode);
        resume  = cont_mode ? SH_RUN : SH_IDLE;
        take    = evt.fall && ((state_q == SH_IDLE && evt.fs) || state_q == SH_RUN);
        shifted = (cnt_q == '0) ? {{(W-1){1'b0}}, evt.dat} : {sh_q[W-2:0], evt.dat};
        last    = take && ((cnt_q + CNT_W'(1)) == len);

        xfer      = (state_q == SH_FULL) ? hold_free : (last && hold_free);
        xfer_word = (state_q == SH_FULL) ? sh_q : shifted;

        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        if (state_q == SH_FULL) begin
            if (hold_free) begin
                state_n = resume;
                cnt_n   = '0;
            end
        end else if (take) begin
            sh_n = shifted;
            if (last) begin
                cnt_n   = '0;
                state_n = hold_free ? resume : SH_FULL;
            end else begin
                cnt_n   = cnt_q + CNT_W'(1);
                state_n = SH_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
        end
    end

    assign sh_full = (state_q == SH_FULL);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         byte_mode,
    input  logic         xfer,
    input  logic [W-1:0] xfer_word,
    input  logic         rd,
    output logic [W-1:0] hold_data,
    output logic         unread,
    output logic         irq,
    output logic         hold_free
);
    logic [W-1:0] hold_q;
    logic         unread_q;
    logic         irq_q;

    // a read in the same cycle frees the register for a completing word
    assign hold_free = ~unread_q | rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            unread_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= xfer;
            if (xfer) begin
                hold_q   <= fit_word(byte_mode, xfer_word);
                unread_q <= 1'b1;
            end else if (rd) begin
                unread_q <= 1'b0;
            end
        end
    end

    assign hold_data = hold_q;
    assign unread    = unread_q;
    assign irq       = irq_q;
endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              cont_mode,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              rx_irq,
    output logic              rx_unread,
    output logic              rx_ovr
);
    ser_evt_t          evt;
    logic              hold_free;
    logic              xfer;
    logic [WORD_W-1:0] xfer_word;

    srx_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .sclk  (sclk),
        .fsync (fsync),
        .sdata (sdata),
        .evt   (evt)
    );

    srx_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .byte_mode (byte_mode),
        .cont_mode (cont_mode),
        .evt       (evt),
        .hold_free (hold_free),
        .xfer      (xfer),
        .xfer_word (xfer_word),
        .sh_full   (rx_ovr)
    );

    srx_hold #(.W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .byte_mode (byte_mode),
        .xfer      (xfer),
        .xfer_word (xfer_word),
        .rd        (rd_strobe),
        .hold_data (rd_data),
        .unread    (rx_unread),
        .irq       (rx_irq),
        .hold_free (hold_free)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              byte_mode,
    input logic              rd_strobe,
    input logic [WORD_W-1:0] rd_data,
    input logic              rx_irq,
    input logic              rx_unread,
    input logic              rx_ovr
);
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!rx_irq && !rx_ovr && !rx_unread && rd_data == '0));

    a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && byte_mode && $past(byte_mode)) |-> (rd_data[WORD_W-1:BYTE_W] == '0));

    a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    a_r5_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (rx_unread && !rd_strobe) |=> $stable(rd_data));

    a_r5_ovr_needs_unread: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> rx_unread);

    a_r6_irq_with_unread: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_unread);

    a_r7_read_releases: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && rd_strobe) |=> (rx_irq && !rx_ovr && rx_unread));
endmodule

bind serial_rx_dbuf srx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .byte_mode (byte_mode),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rx_irq    (rx_irq),
    .rx_unread (rx_unread),
    .rx_ovr    (rx_ovr)
);

// File: tb/serial_rx_dbuf_tb.sv
module serial_rx_dbuf_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        byte_mode, cont_mode;
    logic        sclk, fsync, sdata;
    logic        rd_strobe;
    logic [15:0] rd_data;
    logic        rx_irq, rx_unread, rx_ovr;

    int nchk = 0;
    int nbad = 0;
    int irq_cnt = 0;
    logic rd_req = 1'b0;
    logic auto_rd = 1'b0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    serial_rx_dbuf dut_i (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .cont_mode(cont_mode),
        .sclk(sclk), .fsync(fsync), .sdata(sdata), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_irq(rx_irq), .rx_unread(rx_unread), .rx_ovr(rx_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // host read driver: single-cycle pulses on request or automatically
    initial begin
        rd_strobe = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_strobe) rd_strobe = 1'b0;
            else if (rd_req || (auto_rd && rx_unread)) begin
                rd_strobe = 1'b1;
                rd_req    = 1'b0;
            end
        end
    end

    // monitor: every interrupt must deliver the next expected word
    initial begin
        forever begin
            @(negedge clk);
            if (rx_irq) begin
                irq_cnt++;
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected irq", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R4 delivered word", rd_data, e);
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1; sclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] v, input int n, input bit with_fs);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            fsync = with_fs && (i == n - 1);
            sclk  = 1'b1;
            repeat (3) @(negedge clk);
            sclk  = 1'b0;
            repeat (3) @(negedge clk);
        end
        fsync = 1'b0;
    endtask

    task automatic host_read();
        rd_req = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int base;
        byte_mode = 1'b0; cont_mode = 1'b0;
        do_reset();
        // R1 reset state
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        chk(!rx_unread && !rx_ovr && !rx_irq, "R1 flags",
            {rx_unread, rx_ovr, rx_irq}, 0);

        // R2 burst 16-bit word, MSB first
        exp_q.push_back(16'hA5C3);
        send_word(16'hA5C3, 16, 1);
        repeat (6) @(negedge clk);
        chk(rx_unread == 1'b1, "R4 unread set", rx_unread, 1);
        chk(rd_data == 16'hA5C3, "R2 msb first word", rd_data, 16'hA5C3);
        chk(irq_cnt == 1, "R4 one irq", irq_cnt, 1);

        // R8 plain read
        host_read();
        chk(rx_unread == 1'b0, "R8 unread cleared", rx_unread, 0);
        chk(rd_data == 16'hA5C3, "R8 data kept", rd_data, 16'hA5C3);

        // R11 bits without sync are ignored in burst mode
        send_word(16'hFFFF, 16, 0);
        repeat (6) @(negedge clk);
        chk(irq_cnt == 1, "R11 no word without sync", irq_cnt, 1);
        chk(rx_unread == 1'b0, "R11 unread stays clear", rx_unread, 0);
        exp_q.push_back(16'h1234);
        send_word(16'h1234, 16, 1);
        repeat (6) @(negedge clk);
        chk(rd_data == 16'h1234, "R11 aligned after ignored bits", rd_data, 16'h1234);
        host_read();

        // R3 byte mode
        byte_mode = 1'b1;
        exp_q.push_back(16'h009E);
        send_word(16'h009E, 8, 1);
        repeat (6) @(negedge clk);
        chk(rd_data == 16'h009E, "R3 byte word", rd_data, 16'h009E);
        chk(irq_cnt == 3, "R3 byte irq", irq_cnt, 3);
        host_read();
        byte_mode = 1'b0;

        // R5 / R6 / R7 overrun in burst mode
        do_reset();
        base = irq_cnt;
        exp_q.push_back(16'hBEEF);
        send_word(16'hBEEF, 16, 1);
        send_word(16'h0F0F, 16, 1);
        repeat (6) @(negedge clk);
        chk(rx_ovr == 1'b1, "R5 overrun flag", rx_ovr, 1);
        chk(rd_data == 16'hBEEF, "R5 holding kept", rd_data, 16'hBEEF);
        chk(irq_cnt == base + 1, "R6 no irq on overrun", irq_cnt, base + 1);
        send_word(16'h7777, 16, 1);
        repeat (6) @(negedge clk);
        chk(rd_data == 16'hBEEF, "R5 sync ignored while full", rd_data, 16'hBEEF);
        chk(rx_ovr == 1'b1, "R5 flag held", rx_ovr, 1);
        chk(irq_cnt == base + 1, "R6 no irq on sync while full", irq_cnt, base + 1);
        exp_q.push_back(16'h0F0F);
        host_read();
        chk(rx_ovr == 1'b0, "R7 flag cleared", rx_ovr, 0);
        chk(rd_data == 16'h0F0F, "R7 pending word moved", rd_data, 16'h0F0F);
        chk(rx_unread == 1'b1, "R7 unread kept", rx_unread, 1);
        chk(irq_cnt == base + 2, "R7 irq on release", irq_cnt, base + 2);
        host_read();
        chk(rx_unread == 1'b0, "R8 unread cleared after release", rx_unread, 0);

        // R9 continuous stream, host keeping up
        do_reset();
        cont_mode = 1'b1; auto_rd = 1'b1;
        base = irq_cnt;
        exp_q.push_back(16'h8001);
        exp_q.push_back(16'h3C3C);
        exp_q.push_back(16'hE71A);
        send_word(16'h8001, 16, 1);
        send_word(16'h3C3C, 16, 0);
        send_word(16'hE71A, 16, 0);
        repeat (8) @(negedge clk);
        chk(irq_cnt == base + 3, "R9 three stream words", irq_cnt, base + 3);
        chk(exp_q.size() == 0, "R9 all words seen", exp_q.size(), 0);

        // R10 continuous overrun then resume
        auto_rd = 1'b0;
        do_reset();
        base = irq_cnt;
        exp_q.push_back(16'h1111);
        send_word(16'h1111, 16, 1);
        send_word(16'h2222, 16, 0);
        send_word(16'h3333, 16, 0);
        repeat (6) @(negedge clk);
        chk(rx_ovr == 1'b1, "R10 overrun in stream", rx_ovr, 1);
        chk(rd_data == 16'h1111, "R10 holding kept", rd_data, 16'h1111);
        chk(irq_cnt == base + 1, "R10 no irq on overrun", irq_cnt, base + 1);
        exp_q.push_back(16'h2222);
        host_read();
        chk(rd_data == 16'h2222, "R10 pending released", rd_data, 16'h2222);
        chk(rx_ovr == 1'b0, "R10 flag cleared", rx_ovr, 0);
        auto_rd = 1'b1;
        repeat (4) @(negedge clk);
        exp_q.push_back(16'h4D4D);
        send_word(16'h4D4D, 16, 0);
        repeat (8) @(negedge clk);
        chk(rd_data == 16'h4D4D, "R10 stream resumed", rd_data, 16'h4D4D);
        chk(exp_q.size() == 0, "R10 all words seen", exp_q.size(), 0);
        auto_rd = 1'b0;

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule